// File: doc/BRIEF.md
# Masked Ensemble Averager with Differential Output

The block forms one layer output vector from redundant analog copies of that layer. Each layer weight matrix is held as a positive and a negative conductance matrix. Each of the two matrices is written ALPHA times onto the array. Inputs drive the array columns. Each output is read from one array row in every copy. The digitized row currents reach the block as a stream of 12-bit signed samples. Each sample carries a polarity bit, a copy index and an output index. For each output, a precomputed activity mask selects which copies may contribute. Copies with large conductance deviation are left out this way, and different outputs may select different subsets.

For every output the block accumulates the active positive samples and the active negative samples separately. When the last sample of a frame arrives, it takes the difference and scales it with one programmable Q1.15 reciprocal. That constant folds together 1/beta (beta being the number of active copies), 1/(G_on − G_off) and 1/V_read. The rounded products are streamed out in output-index order over a valid/ready handshake.

The weight convention is differential. A ternary weight of +η uses a device pair at (ON, OFF) in (positive, negative) order, 0 uses (ON, ON), and −η uses (OFF, ON). As a result, equal positive and negative currents cancel to zero.

Top module: `ens_avg_diff`

## Requirements
- R1: After reset `res_valid` is 0 and `smp_ready` is 1.
- R2: An accepted sample adds to the accumulator of its output and polarity only when mask bit `act_mask[out*ALPHA + copy]` is 1. Samples whose mask bit is 0 have no effect on the result.
- R3: Each output uses its own mask bits, so two outputs fed identical samples may give different results.
- R4: The result for output o is floor(((P − N) · S + 2^14) / 2^15). P is the sum of active samples with `smp_neg`=0, N is the sum of active samples with `smp_neg`=1, and S is the unsigned 16-bit Q1.15 scale.
- R5: The scale is captured when the sample flagged `smp_last` is accepted. Changes on `scale_q15` while results are being emitted do not affect them.
- R6: After a frame closes, results appear with `res_idx` = 0, 1, …, NOUT−1, one per valid/ready transfer.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_idx` and `res_data` hold steady.
- R8: `smp_ready` is 0 while results are pending. After the last result transfers, the block accepts samples again and all sums restart from zero.
- R9: ALPHA full-scale samples of either sign accumulate without overflow. A full-scale positive minus full-scale negative difference, scaled by 0x7FFF, is exact to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Block accepts samples |
| smp_neg | input | 1 | 0: positive-matrix copy, 1: negative-matrix copy |
| smp_copy | input | $clog2(ALPHA) | Redundant copy index |
| smp_out | input | $clog2(NOUT) | Output (row) index |
| smp_data | input | 12 | Signed ADC sample |
| smp_last | input | 1 | Last sample of the frame |
| act_mask | input | NOUT*ALPHA | Active-copy mask, bit out*ALPHA+copy |
| scale_q15 | input | 16 | Unsigned Q1.15 reciprocal of beta·Gnorm·Vread |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer ready |
| res_idx | output | $clog2(NOUT) | Output index of the result |
| res_data | output | ADC_W+$clog2(ALPHA+1)+2 | Signed scaled difference |

## Verification
The bench builds the block with ALPHA=3 and NOUT=5. Neither is a power of two, so the copy and output index fields contain codes that do not map to a copy or output, and the mask-bit arithmetic cannot reduce to a bit concatenation. Three copies also make the accumulator width bound from R9 tight: three full-scale samples of 2048 nearly fill 14 bits. The bench mixes random masks, samples, scales and ready patterns with directed frames: an empty mask, an all-active full-scale frame, and a frame of ternary device-pair currents.

// File: rtl/ens_avg_diff.sv
module ens_avg_diff #(
  parameter int ALPHA = 4,
  parameter int NOUT  = 4,
  parameter int ADC_W = 12,
  localparam int CW     = $clog2(ALPHA),
  localparam int OW     = $clog2(NOUT),
  localparam int ACC_W  = ADC_W + $clog2(ALPHA + 1),
  localparam int DIFF_W = ACC_W + 1,
  localparam int RES_W  = DIFF_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic                    smp_neg,
  input  logic [CW-1:0]           smp_copy,
  input  logic [OW-1:0]           smp_out,
  input  logic signed [ADC_W-1:0] smp_data,
  input  logic                    smp_last,
  input  logic [NOUT*ALPHA-1:0]   act_mask,
  input  logic [15:0]             scale_q15,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [OW-1:0]           res_idx,
  output logic signed [RES_W-1:0] res_data
);
  localparam int PROD_W = DIFF_W + 17;

  logic signed [ACC_W-1:0] pacc [NOUT];
  logic signed [ACC_W-1:0] nacc [NOUT];
  logic [15:0]   scale_q;
  logic          emit;
  logic [OW-1:0] ptr;

  wire take     = smp_valid && smp_ready;
  wire in_range = (int'(smp_copy) < ALPHA) && (int'(smp_out) < NOUT);
  wire hit      = in_range && act_mask[int'(smp_out) * ALPHA + int'(smp_copy)];
  wire done     = emit && res_ready && (int'(ptr) == NOUT - 1);

  assign smp_ready = !emit;
  assign res_valid = emit;
  assign res_idx   = ptr;

  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] prod, rnd;
  assign diff = DIFF_W'(pacc[ptr]) - DIFF_W'(nacc[ptr]);
  assign prod = PROD_W'(diff) * PROD_W'($signed({1'b0, scale_q}));
  assign rnd  = prod + (PROD_W'(1) <<< 14);
  assign res_data = RES_W'(rnd >>> 15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < NOUT; o++) begin
        pacc[o] <= '0;
        nacc[o] <= '0;
      end
      scale_q <= '0;
      emit    <= 1'b0;
      ptr     <= '0;
    end else begin
      if (done) begin
        for (int o = 0; o < NOUT; o++) begin
          pacc[o] <= '0;
          nacc[o] <= '0;
        end
        emit <= 1'b0;
        ptr  <= '0;
      end else if (emit && res_ready) begin
        ptr <= ptr + 1'b1;
      end
      if (take && hit) begin
        if (smp_neg) nacc[smp_out] <= nacc[smp_out] + ACC_W'(smp_data);
        else         pacc[smp_out] <= pacc[smp_out] + ACC_W'(smp_data);
      end
      if (take && smp_last) begin
        emit    <= 1'b1;
        ptr     <= '0;
        scale_q <= scale_q15;
      end
    end
  end

  // R7: stalled result held
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_idx) && $stable(res_data));

  // R6: indices step by one per transfer
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && (int'(res_idx) != NOUT - 1) |=> res_valid && (res_idx == $past(res_idx) + 1'b1));

  // R6: emission starts at index zero
  a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> res_idx == '0);

  // R5: captured scale frozen during emission
  a_r5_scale: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !(res_ready && int'(res_idx) == NOUT - 1) |=> $stable(scale_q));

  // R8: last transfer reopens the input
  a_r8_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && (int'(res_idx) == NOUT - 1) |=> !res_valid && smp_ready);

  // R9: sums stay within ALPHA full-scale samples
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pacc[ptr]) <= ALPHA * (2 ** (ADC_W - 1))) && (int'(pacc[ptr]) >= -ALPHA * (2 ** (ADC_W - 1))) &&
    (int'(nacc[ptr]) <= ALPHA * (2 ** (ADC_W - 1))) && (int'(nacc[ptr]) >= -ALPHA * (2 ** (ADC_W - 1))));
endmodule

// File: tb/ens_avg_diff_tb.sv
module ens_avg_diff_tb;
  localparam int ALPHA = 3;
  localparam int NOUT  = 5;
  localparam int ADC_W = 12;
  localparam int CW    = $clog2(ALPHA);
  localparam int OW    = $clog2(NOUT);
  localparam int RES_W = ADC_W + $clog2(ALPHA + 1) + 2;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, smp_neg = 0, smp_last = 0, res_ready = 0;
  logic [CW-1:0] smp_copy = '0;
  logic [OW-1:0] smp_out = '0;
  logic signed [ADC_W-1:0] smp_data = '0;
  logic [NOUT*ALPHA-1:0] act_mask = '0;
  logic [15:0] scale_q15 = '0;
  logic smp_ready, res_valid;
  logic [OW-1:0] res_idx;
  logic signed [RES_W-1:0] res_data;

  ens_avg_diff #(.ALPHA(ALPHA), .NOUT(NOUT), .ADC_W(ADC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_neg(smp_neg), .smp_copy(smp_copy), .smp_out(smp_out), .smp_data(smp_data),
    .smp_last(smp_last), .act_mask(act_mask), .scale_q15(scale_q15),
    .res_valid(res_valid), .res_ready(res_ready), .res_idx(res_idx), .res_data(res_data));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int ps [NOUT][ALPHA];
  int ns [NOUT][ALPHA];
  bit hung = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !hung) begin
      hung = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expect_out(int o, logic [NOUT*ALPHA-1:0] m, int s);
    longint p = 0, n = 0;
    for (int c = 0; c < ALPHA; c++)
      if (m[o*ALPHA + c]) begin p += ps[o][c]; n += ns[o][c]; end
    return ((p - n) * s + 16384) >>> 15;
  endfunction

  // kind: 0 random, 1 full scale, 2 ternary pairs
  task automatic run_frame(logic [NOUT*ALPHA-1:0] m, int s, int kind, string req);
    int k = 0;
    longint exp;
    for (int o = 0; o < NOUT; o++)
      for (int c = 0; c < ALPHA; c++) begin
        if (kind == 1) begin ps[o][c] = 2047; ns[o][c] = -2048; end
        else if (kind == 2) begin
          ps[o][c] = (o % 3 == 2) ? 700 : 1165;
          ns[o][c] = (o % 3 == 0) ? 700 : 1165;
        end else begin
          ps[o][c] = int'($urandom_range(0, 4095)) - 2048;
          ns[o][c] = int'($urandom_range(0, 4095)) - 2048;
        end
      end
    act_mask = m;
    for (int o = 0; o < NOUT; o++)
      for (int c = 0; c < ALPHA; c++)
        for (int g = 0; g < 2; g++) begin
          while ($urandom_range(0, 3) == 0) begin
            @(negedge clk); smp_valid = 0;
          end
          @(negedge clk);
          scale_q15 = 16'(s);
          smp_valid = 1; smp_neg = g[0];
          smp_copy = CW'(c); smp_out = OW'(o);
          smp_data = ADC_W'(g == 0 ? ps[o][c] : ns[o][c]);
          smp_last = (o == NOUT-1 && c == ALPHA-1 && g == 1);
        end
    @(negedge clk);
    smp_valid = 0; smp_last = 0;
    while (k < NOUT) begin
      scale_q15 = 16'($urandom);  // R5 ignored
      if (res_valid) begin
        check("R8 ready low", smp_ready, 0);
        check("R6 index", res_idx, k);
        exp = expect_out(k, m, s);
        check(req, res_data, exp);
        res_ready = ($urandom_range(0, 2) != 0);
        if (res_ready) k++;
      end else begin
        res_ready = 0;
        check("R6 valid pending", 0, 1);
        k++;
      end
      @(negedge clk);
      if (!res_ready && k < NOUT) check("R7 hold", res_valid, 1);
    end
    res_ready = 0;
    check("R8 reopened valid", res_valid, 0);
    check("R8 reopened ready", smp_ready, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R1 valid", res_valid, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid", res_valid, 0);
    check("R1 ready", smp_ready, 1);
    run_frame('0, 32767, 0, "R2 empty mask");
    run_frame('1, 32767, 1, "R9 full scale");
    run_frame('1, 10923, 2, "R4 ternary");
    for (int f = 0; f < 12; f++)
      run_frame(NOUT*ALPHA'($urandom), int'($urandom_range(0, 65535)), 0, "R3 R4 random mask");
    run_frame(NOUT*ALPHA'(15'b101_011_110_001_100), 16384, 0, "R2 R3 per-output mask");
    run_frame('1, 1, 0, "R8 restart from zero");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule